// File: doc/BRIEF.md
# Add-Only Memory Command Sequencer

This block is the byte-level command engine of a one-time-programmable data store. The store holds a 128-byte data field in four 32-byte pages and an 8-byte status field. A serial bit layer, which lies outside the block, hands it each received byte, each request for a byte to send back, a bus reset indication and a programming pulse indication. The block decodes a one-byte opcode and collects a two-byte start address, plus one data byte for a write. It then answers with a CRC-8 over the bytes it accepted. After that CRC it streams data, inserting CRC bytes where the command calls for them, or it programs one byte.

Programming can only clear bits: the stored byte becomes the old value ANDed with the new data. Status byte 0 carries one write-enable bit per page. That byte is fixed by a parameter and models a protection pattern that was already programmed. Bytes are presented whole, and the serial layer shifts each one least significant bit first.

Top module: `addonly_seq`

## Requirements
- R1: After `rst_n` is low at a clock edge, the block waits for an opcode. Any byte requested before a header is complete reads FFh.
- R2: Four opcodes are recognised: F0h (stream data), C3h (stream data by page), AAh (stream status) and 0Fh (write). A header is the opcode, then the address low byte, then the address high byte, then a data byte for 0Fh only. The first byte requested after the header is a CRC-8 over those bytes. The CRC uses polynomial x^8+x^5+x^4+1, is bit-reflected, starts from 00h and takes each byte bit 0 first. Address bits above the field width (7 bits for data, 3 bits for status) are forced to zero before they enter the CRC and the pointer.
- R3: For F0h, data streams from the start address through byte 127. Then one CRC byte over the bytes streamed follows, then FFh for every later request.
- R4: For C3h, each byte at page offset 31 is followed by a CRC byte over the bytes read since the previous CRC. Streaming then resumes at the next page. After the CRC of page 3, every request reads FFh.
- R5: For AAh, status bytes stream from the start address through byte 7, then a CRC over them, then FFh. Status byte 0 is the protect byte: bit p enables writes to page p, and the upper bits read 1. Bytes 1 to 6 read FFh and byte 7 reads 00h.
- R6: After reset every data byte reads FFh.
- R7: After a 0Fh header and its CRC, a programming pulse makes the addressed byte equal to its old value ANDed with the data byte. The next request returns the stored byte, and later requests return FFh.
- R8: A programming pulse aimed at a page whose protect bit is 0 leaves the byte unchanged, and the verify byte shows the old value. Reads of that page still work.
- R9: A programming pulse is ignored in every state other than the one after a write header's CRC has been sent.
- R10: `bus_reset` aborts any command at any point and no trailing CRC is produced. The next requested byte is FFh, and a new header is accepted.
- R11: An unknown opcode makes every later request return FFh until `bus_reset` or `rst_n`. Received bytes are ignored in that state.
- R12: `tx_valid` is high exactly in the cycle after each `tx_req`, and `tx_byte` is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also erases the data field |
| bus_reset | input | 1 | One-cycle bus reset indication from the bit layer |
| rx_valid | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte, bit 0 was first on the wire |
| tx_req | input | 1 | The bit layer asks for the next byte to send |
| prog_pulse | input | 1 | One-cycle indication that a programming pulse was applied |
| tx_valid | output | 1 | Answer to the previous cycle's `tx_req` |
| tx_byte | output | 8 | Byte to send, bit 0 first |

## Verification
The checks that run on every cycle cover these points:
- A bus reset returns the sequencer to opcode wait.
- The all-ones state holds and only ever emits FFh.
- Every byte request is answered on the next cycle.
- A programming pulse never sets a bit.
- A pulse aimed at a protected page leaves the byte unchanged.

Only the bench scenarios can show the rest: the CRC values after the header and at segment ends, where page and field boundaries fall under each opcode, the effect of address truncation, and that aborted streams lose their CRC.

// File: rtl/addonly_pkg.sv
// Shared definitions for the add-only memory sequencer: opcodes,
// sequencer states and the reflected CRC-8 step (x^8+x^5+x^4+1).
// Assumes bytes enter the CRC bit 0 first.
package addonly_pkg;

    localparam logic [7:0] OP_STREAM = 8'hF0;
    localparam logic [7:0] OP_PAGED  = 8'hC3;
    localparam logic [7:0] OP_STATUS = 8'hAA;
    localparam logic [7:0] OP_WRITE  = 8'h0F;
    localparam logic [7:0] CRC_REFL  = 8'h8C;

    typedef enum logic [3:0] {
        ST_CMD, ST_ADL, ST_ADH, ST_DAT, ST_HCRC,
        ST_READ, ST_RCRC, ST_PROG, ST_ONES
    } seq_state_t;

    // Fold one byte into the running CRC, least significant bit first.
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] acc;
        logic       mix;
        acc = c;
        for (int b = 0; b < 8; b++) begin
            mix = acc[0] ^ d[b];
            acc = acc >> 1;
            if (mix) acc = acc ^ CRC_REFL;
        end
        return acc;
    endfunction

endpackage

// File: rtl/addonly_crc8.sv
// Running CRC-8 accumulator. A clear restarts it at 00h. Clear and
// update in the same cycle give the CRC of the single byte presented.
module addonly_crc8 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       upd,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    import addonly_pkg::*;

    logic [7:0] base;

    // Select the starting value: zero on clear, otherwise the running sum.
    always_comb base = clr ? 8'h00 : crc;

    // Advance the accumulator by one byte when asked.
    always_ff @(posedge clk) begin
        if (!rst_n) crc <= 8'h00;
        else        crc <= upd ? crc8_step(base, din) : base;
    end
endmodule

// File: rtl/addonly_store.sv
// Data field (erased to FFh on reset) and the read-only status field.
// Programming ANDs data into the addressed byte when its page is enabled
// in PROTECT_INIT (bit p = page p). Assumes at most 8 pages and at most
// 256 bytes per field.
module addonly_store #(
    parameter int         DATA_BYTES   = 128,
    parameter int         PAGE_BYTES   = 32,
    parameter int         STAT_BYTES   = 8,
    parameter logic [7:0] PROTECT_INIT = 8'hFF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(DATA_BYTES)-1:0] addr_data,
    input  logic [$clog2(STAT_BYTES)-1:0] addr_stat,
    input  logic                          prog_req,
    input  logic [7:0]                    prog_data,
    output logic [7:0]                    rd_data,
    output logic [7:0]                    rd_stat
);
    localparam int AW     = $clog2(DATA_BYTES);
    localparam int PW     = $clog2(PAGE_BYTES);
    localparam int NPAGES = DATA_BYTES / PAGE_BYTES;
    localparam logic [7:0] PAGE_MASK  = 8'((1 << NPAGES) - 1);
    localparam logic [7:0] STAT_BYTE0 = PROTECT_INIT | ~PAGE_MASK;

    logic [7:0] mem_q    [DATA_BYTES];
    logic [7:0] stat_rom [STAT_BYTES];
    logic       wr_ok;

    // Page write enable taken from the protect byte.
    always_comb wr_ok = PROTECT_INIT[3'(addr_data[AW-1:PW])];

    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_byte
        // Erase on reset, clear bits on an enabled programming pulse.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[i] <= 8'hFF;
            else if (prog_req && wr_ok && addr_data == AW'(i))
                mem_q[i] <= mem_q[i] & prog_data;
        end
    end

    for (genvar s = 0; s < STAT_BYTES; s++) begin : g_stat
        if (s == 0) begin : g_prot
            assign stat_rom[s] = STAT_BYTE0;
        end else if (s == STAT_BYTES - 1) begin : g_tail
            assign stat_rom[s] = 8'h00;
        end else begin : g_free
            assign stat_rom[s] = 8'hFF;
        end
    end

    // Read ports follow the pointers combinationally.
    always_comb begin
        rd_data = mem_q[addr_data];
        rd_stat = stat_rom[addr_stat];
    end

    AST_BITS_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> ((rd_data & ~$past(rd_data)) == 8'h00)); // R7
    AST_PROTECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && !wr_ok) |=> $stable(rd_data)); // R8
endmodule

// File: rtl/addonly_seq.sv
// Command sequencer for the add-only memory. It takes received bytes,
// byte requests, bus reset and programming pulses from a serial layer and
// answers every tx_req one cycle later. Assumes DATA_BYTES and STAT_BYTES
// are powers of two no larger than 256, and DATA_BYTES is a multiple of
// PAGE_BYTES.
module addonly_seq #(
    parameter int         DATA_BYTES   = 128,
    parameter int         PAGE_BYTES   = 32,
    parameter int         STAT_BYTES   = 8,
    parameter logic [7:0] PROTECT_INIT = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_reset,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_req,
    input  logic       prog_pulse,
    output logic       tx_valid,
    output logic [7:0] tx_byte
);
    import addonly_pkg::*;

    localparam int AW = $clog2(DATA_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int SW = $clog2(STAT_BYTES);
    localparam logic [7:0] DATA_MASK = 8'(DATA_BYTES - 1);
    localparam logic [7:0] STAT_MASK = 8'(STAT_BYTES - 1);

    seq_state_t    state_q, state_d;
    logic [AW-1:0] ptr_q, ptr_d;
    logic [7:0]    cmd_q, cmd_d, data_q, data_d, tx_d, crc_q, crc_din;
    logic [7:0]    rd_data, rd_stat, rd_byte, rx_masked;
    logic          last_q, last_d, crc_clr, crc_upd, prog_req;
    logic          is_stat, is_write, seg_end, field_end, op_ok;

    addonly_crc8 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd),
        .din(crc_din), .crc(crc_q)
    );

    addonly_store #(
        .DATA_BYTES(DATA_BYTES), .PAGE_BYTES(PAGE_BYTES),
        .STAT_BYTES(STAT_BYTES), .PROTECT_INIT(PROTECT_INIT)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .addr_data(ptr_q), .addr_stat(ptr_q[SW-1:0]),
        .prog_req(prog_req), .prog_data(data_q), .rd_data(rd_data), .rd_stat(rd_stat)
    );

    // Decode the latched command and the boundaries of the current byte.
    always_comb begin
        is_stat   = (cmd_q == OP_STATUS);
        is_write  = (cmd_q == OP_WRITE);
        op_ok     = (rx_byte == OP_STREAM) || (rx_byte == OP_PAGED) ||
                    (rx_byte == OP_STATUS) || (rx_byte == OP_WRITE);
        rx_masked = rx_byte & (is_stat ? STAT_MASK : DATA_MASK);
        rd_byte   = is_stat ? rd_stat : rd_data;
        field_end = is_stat ? (ptr_q[SW-1:0] == SW'(STAT_BYTES - 1))
                            : (ptr_q == AW'(DATA_BYTES - 1));
        seg_end   = (cmd_q == OP_PAGED) ? (ptr_q[PW-1:0] == PW'(PAGE_BYTES - 1))
                                        : field_end;
    end

    // Next-state, pointer, CRC control and answer byte for this cycle.
    always_comb begin
        state_d  = state_q;
        ptr_d    = ptr_q;
        cmd_d    = cmd_q;
        data_d   = data_q;
        last_d   = last_q;
        tx_d     = 8'hFF;
        crc_clr  = 1'b0;
        crc_upd  = 1'b0;
        crc_din  = rx_byte;
        prog_req = 1'b0;
        if (bus_reset) begin
            state_d = ST_CMD;
            crc_clr = 1'b1;
        end else begin
            case (state_q)
                ST_CMD: if (rx_valid) begin
                    cmd_d = rx_byte;
                    if (op_ok) begin
                        state_d = ST_ADL;
                        crc_clr = 1'b1;
                        crc_upd = 1'b1;
                    end else begin
                        state_d = ST_ONES;
                    end
                end
                ST_ADL: if (rx_valid) begin
                    crc_din = rx_masked;
                    crc_upd = 1'b1;
                    ptr_d   = rx_masked[AW-1:0];
                    state_d = ST_ADH;
                end
                ST_ADH: if (rx_valid) begin
                    crc_din = 8'h00;
                    crc_upd = 1'b1;
                    state_d = is_write ? ST_DAT : ST_HCRC;
                end
                ST_DAT: if (rx_valid) begin
                    data_d  = rx_byte;
                    crc_upd = 1'b1;
                    state_d = ST_HCRC;
                end
                ST_HCRC: if (tx_req) begin
                    tx_d    = crc_q;
                    crc_clr = 1'b1;
                    state_d = is_write ? ST_PROG : ST_READ;
                end
                ST_READ: if (tx_req) begin
                    tx_d    = rd_byte;
                    crc_din = rd_byte;
                    crc_upd = 1'b1;
                    ptr_d   = ptr_q + AW'(1);
                    if (seg_end) begin
                        state_d = ST_RCRC;
                        last_d  = field_end;
                    end
                end
                ST_RCRC: if (tx_req) begin
                    tx_d    = crc_q;
                    crc_clr = 1'b1;
                    state_d = last_q ? ST_ONES : ST_READ;
                end
                ST_PROG: begin
                    prog_req = prog_pulse;
                    if (tx_req) begin
                        tx_d    = rd_data;
                        state_d = ST_ONES;
                    end
                end
                default: ;
            endcase
        end
    end

    // Register sequencer state and the answer to each byte request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_CMD;
            ptr_q    <= '0;
            cmd_q    <= 8'h00;
            data_q   <= 8'hFF;
            last_q   <= 1'b0;
            tx_valid <= 1'b0;
            tx_byte  <= 8'hFF;
        end else begin
            state_q  <= state_d;
            ptr_q    <= ptr_d;
            cmd_q    <= cmd_d;
            data_q   <= data_d;
            last_q   <= last_d;
            tx_valid <= tx_req;
            tx_byte  <= tx_d;
        end
    end

    AST_BUS_RESET_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (state_q == ST_CMD)); // R10
    AST_ONES_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ONES && !bus_reset) |=> (state_q == ST_ONES)); // R11
    AST_ONES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_ONES && $past(tx_req)) |-> (tx_byte == 8'hFF)); // R3
    AST_TX_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> tx_valid); // R12
endmodule

// File: tb/addonly_seq_test.sv
module addonly_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic       bus_reset = 1'b0, rx_valid = 1'b0, tx_req = 1'b0, prog_pulse = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tv_a, tv_b, tx_valid;
    logic [7:0] tb_a, tb_b, tx_byte;
    int         checks = 0, failures = 0;
    logic       done = 1'b0;
    logic [7:0] model [128];

    always #5 clk = ~clk;

    addonly_seq uut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset & ~sel), .rx_valid(rx_valid & ~sel),
        .rx_byte(rx_byte), .tx_req(tx_req & ~sel), .prog_pulse(prog_pulse & ~sel),
        .tx_valid(tv_a), .tx_byte(tb_a));

    addonly_seq #(.PROTECT_INIT(8'hFD)) uut_wp (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset & sel), .rx_valid(rx_valid & sel),
        .rx_byte(rx_byte), .tx_req(tx_req & sel), .prog_pulse(prog_pulse & sel),
        .tx_valid(tv_b), .tx_byte(tb_b));

    assign tx_valid = sel ? tv_b : tv_a;
    assign tx_byte  = sel ? tb_b : tb_a;

    // Stimulus table: {opcode, address (16 bits), write data}.
    localparam logic [31:0] VEC [0:7] = '{
        32'hF0_0000_00, 32'hAA_0003_00, 32'hC3_001E_00, 32'h0F_0005_A5,
        32'h0F_0005_3C, 32'hF0_1234_00, 32'h0F_FF85_0F, 32'hAA_00FF_00 };

    function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] a = c;
        for (int i = 0; i < 8; i++) begin
            logic m = a[0] ^ d[i];
            a = a >> 1;
            if (m) a = a ^ 8'h8C;
        end
        return a;
    endfunction

    function automatic logic [7:0] stat_m(input int i, input logic [7:0] prot);
        if (i == 0) return prot;
        if (i == 7) return 8'h00;
        return 8'hFF;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic get(output logic [7:0] b);
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        if (!tx_valid) begin
            failures++;
            $display("FAIL R12 actual=tx_valid 0 expected=1");
        end
        b = tx_byte;
    endtask

    task automatic pulse_prog();
        @(negedge clk); prog_pulse = 1'b1;
        @(negedge clk); prog_pulse = 1'b0;
    endtask

    task automatic pulse_bus();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    // Send a header and check the CRC answer; returns the truncated address.
    task automatic header(input logic [7:0] op, input logic [15:0] a, input logic [7:0] d,
                          output int eff);
        logic [7:0] m, c, got;
        m   = a[7:0] & ((op == 8'hAA) ? 8'h07 : 8'h7F);
        eff = int'(m);
        c   = crc_b(crc_b(crc_b(8'h00, op), m), 8'h00);
        send(op); send(a[7:0]); send(a[15:8]);
        if (op == 8'h0F) begin
            send(d);
            c = crc_b(c, d);
        end
        get(got);
        check8("R2 header crc", got, c);
    endtask

    // Stream to the end of the field with every CRC, then two FFh bytes.
    task automatic stream(input logic [7:0] op, input int start, input logic [7:0] prot,
                          input string req);
        int         p = start, last = (op == 8'hAA) ? 7 : 127, bad = 0;
        logic [7:0] c = 8'h00, e, got, ba = 8'h00, be = 8'h00;
        logic       fin = 1'b0;
        while (!fin) begin
            e = (op == 8'hAA) ? stat_m(p, prot) : model[p];
            get(got);
            if (got !== e && bad == 0) begin ba = got; be = e; end
            if (got !== e) bad++;
            c = crc_b(c, e);
            if (p == last || (op == 8'hC3 && p % 32 == 31)) begin
                get(got);
                if (got !== c && bad == 0) begin ba = got; be = c; end
                if (got !== c) bad++;
                c = 8'h00;
                if (p == last) fin = 1'b1;
            end
            p++;
        end
        for (int k = 0; k < 2; k++) begin
            get(got);
            if (got !== 8'hFF && bad == 0) begin ba = got; be = 8'hFF; end
            if (got !== 8'hFF) bad++;
        end
        checks++;
        if (bad != 0) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, ba, be);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        int         eff;
        for (int i = 0; i < 128; i++) model[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (tx_valid !== 1'b0) begin
            failures++;
            $display("FAIL R12 actual=%0b expected=0", tx_valid);
        end
        get(got); check8("R1 before header", got, 8'hFF);

        // Table walk: header CRC, then stream or program and verify.
        for (int v = 0; v < 8; v++) begin
            logic [7:0] op = VEC[v][31:24];
            pulse_bus();
            header(op, VEC[v][23:8], VEC[v][7:0], eff);
            if (op == 8'h0F) begin
                pulse_prog();
                model[eff] = model[eff] & VEC[v][7:0];
                get(got); check8("R7 verify", got, model[eff]);
                get(got); check8("R7 after verify", got, 8'hFF);
            end else begin
                stream(op, eff, 8'hFF, (op == 8'hAA) ? "R5 status stream" :
                       (op == 8'hC3) ? "R4 paged stream" :
                       (v == 0) ? "R6 erased stream" : "R3 data stream");
            end
        end

        pulse_bus(); header(8'hF0, 16'h0000, 8'h00, eff);
        stream(8'hF0, 0, 8'hFF, "R3 stream after writes");

        // Abort mid-stream: no CRC, then a new header works.
        pulse_bus(); header(8'hC3, 16'h001E, 8'h00, eff);
        get(got); get(got);
        pulse_bus();
        get(got); check8("R10 no crc after abort", got, 8'hFF);
        header(8'hAA, 16'h0000, 8'h00, eff);
        stream(8'hAA, 0, 8'hFF, "R5 status after abort");

        // Unknown opcode.
        pulse_bus(); send(8'h55); send(8'hF0); send(8'h00);
        get(got); check8("R11 unknown opcode", got, 8'hFF);
        get(got); check8("R11 stays ones", got, 8'hFF);

        // Programming pulses outside the programming state.
        pulse_bus(); send(8'h0F); send(8'h40); send(8'h00); send(8'h00);
        pulse_prog();
        get(got); check8("R9 header crc after stray pulse",
                         got, crc_b(crc_b(crc_b(crc_b(8'h00, 8'h0F), 8'h40), 8'h00), 8'h00));
        get(got); check8("R9 no program without pulse", got, 8'hFF);
        pulse_bus(); header(8'hF0, 16'h0040, 8'h00, eff);
        pulse_prog();
        get(got); check8("R9 pulse during read", got, 8'hFF);

        // Protected page on the second instance (page 1 locked).
        sel = 1'b1;
        pulse_bus(); header(8'hAA, 16'h0000, 8'h00, eff);
        get(got); check8("R5 protect byte", got, 8'hFD);
        pulse_bus(); header(8'h0F, 16'h0025, 8'h00, eff);
        pulse_prog();
        get(got); check8("R8 protected verify", got, 8'hFF);
        pulse_bus(); header(8'h0F, 16'h0002, 8'h00, eff);
        pulse_prog();
        get(got); check8("R8 open page programs", got, 8'h00);
        pulse_bus(); header(8'hF0, 16'h0025, 8'h00, eff);
        get(got); check8("R8 protected page readable", got, 8'hFF);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule